// File: doc/BRIEF.md
# Six-Phase Demultiplex Strobe Generator

This block produces the timing strobes that spread a serial stream of video samples across six parallel hold channels. A capture strobe fires once for each accepted sample and walks through the channels in turn. After the sixth channel has been filled, transfer strobes move the held values into an output stage. The transfer covers all six channels at once, or it covers them as a lower group (channels 1 to 3) and an upper group (channels 4 to 6) half a dot apart.

The block runs on an internal clock at twice the dot rate, so one internal cycle equals half a dot. In single-chip mode a sample is accepted every dot, which is two internal cycles. In two-chip mode a sample is accepted every second dot, which is four internal cycles. In that mode a six-channel cycle spans twelve input samples of the shared stream.

Each falling edge of the horizontal sync input restarts the sequence. At that edge the block also samples the scan direction, the group-transfer choice, the 4-bit output phase delay and the rate mode. A separate monitor flags a sync edge and a polarity edge that come too close together.

Top module: `dmx6_strobe_gen`

## Requirements
- R1: Exactly zero or one bit of `cap_stb` is high in any cycle. After a sync falling edge and its delay, one capture occurs every 2 cycles in single mode (`dual_chip`=0) and every 4 cycles in two-chip mode (`dual_chip`=1).
- R2: With `dir_asc`=1 latched, successive captures assert `cap_stb` bits 0,1,2,3,4,5 and then repeat; bit k stands for channel k+1.
- R3: With `dir_asc`=0 latched, successive captures assert `cap_stb` bits 5,4,3,2,1,0 and then repeat.
- R4: With `split_grp`=0 latched, `xfer_lo` and `xfer_hi` pulse together for one cycle, in the cycle after the sixth capture of each cycle.
- R5: With `split_grp`=1 latched, `xfer_lo` pulses in the cycle after the sixth capture and `xfer_hi` pulses one cycle (half a dot) later; the two are never high together.
- R6: The first capture after a sync fall seen at clock edge N appears in the cycle after edge N+D, where D = `phase_sel` in single mode and D = 2·`phase_sel` in two-chip mode.
- R7: A sync falling edge restarts the sequence. The next capture goes to the first channel of the newly latched direction, and any transfer strobe still pending is cancelled.
- R8: The values of `dir_asc`, `split_grp`, `phase_sel` and `dual_chip` take effect only at a sync falling edge. Changing them in the middle of a line does not alter the strobes.
- R9: `timing_err` pulses for one cycle when a sync fall and a `pol` edge are fewer than MIN_GAP (60) internal cycles apart, or when they happen on the same edge. Two events of the same kind never raise it.
- R10: After reset, and until the first sync falling edge, all strobes and `timing_err` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock at twice the dot rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsync | input | 1 | Horizontal sync; its falling edge restarts the line |
| pol | input | 1 | Drive-polarity input; used only for the spacing check |
| dir_asc | input | 1 | 1: channel order 1 to 6; 0: channel order 6 to 1 |
| split_grp | input | 1 | 1: two group transfers half a dot apart; 0: one common transfer |
| phase_sel | input | 4 | Output phase delay setting, 0 to 15 |
| dual_chip | input | 1 | 1: two-chip rate (one sample per 2 dots); 0: single rate |
| cap_stb | output | 6 | Per-channel capture strobes |
| xfer_lo | output | 1 | Transfer strobe for channels 1 to 3 |
| xfer_hi | output | 1 | Transfer strobe for channels 4 to 6 |
| timing_err | output | 1 | Sync/polarity spacing violation pulse |

## Verification
The hardest case to reach from the ports is a sync fall that lands while a transfer is still pending. This happens between the sixth capture and the delayed upper-group strobe. It also happens during the phase countdown. The stimulus uses lines just long enough in split two-chip mode, so that the restart hits exactly the cycle of the delayed strobe. It also changes every setting in the middle of a line to show that only the values at the edge count. A behavioural model in the bench derives the expected strobes from the cycle count since the last sync fall. The bench compares them with the outputs on every cycle.

// File: rtl/dmx6_pkg.sv
package dmx6_pkg;
  // Internal cycles (half dots) between accepted samples.
  function automatic int unsigned period_of(input logic dual);
    return dual ? 32'd4 : 32'd2;
  endfunction

  // Delay in half dots: one dot per step in two-chip mode, half a dot in single mode.
  function automatic int unsigned delay_of(input int unsigned ph, input logic dual);
    return dual ? 2 * ph : ph;
  endfunction

  // Channel receiving the idx-th sample of a cycle.
  function automatic int unsigned chan_of(input int unsigned idx, input logic asc,
                                          input int unsigned nch);
    return asc ? idx : (nch - 1 - idx);
  endfunction
endpackage

// File: rtl/dmx6_sync_capture.sv
module dmx6_sync_capture #(
  parameter int PHASE_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hsync,
  input  logic               pol,
  input  logic               dir_asc,
  input  logic               split_grp,
  input  logic               dual_chip,
  output logic               sync_fall,
  output logic               pol_edge,
  output logic               dir_l,
  output logic               split_l,
  output logic               dual_l
);
  logic hsync_q, pol_q;

  assign sync_fall = hsync_q & ~hsync;
  assign pol_edge  = pol_q ^ pol;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hsync_q <= 1'b0;
      pol_q   <= 1'b0;
      dir_l   <= 1'b1;
      split_l <= 1'b0;
      dual_l  <= 1'b0;
    end else begin
      hsync_q <= hsync;
      pol_q   <= pol;
      if (sync_fall) begin
        dir_l   <= dir_asc;
        split_l <= split_grp;
        dual_l  <= dual_chip;
      end
    end
  end
endmodule

// File: rtl/dmx6_sequencer.sv
module dmx6_sequencer
  import dmx6_pkg::*;
#(
  parameter int NCH     = 6,
  parameter int PHASE_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sync_fall,
  input  logic [PHASE_W-1:0] phase_sel,
  input  logic               dual_chip,
  input  logic               dir_l,
  input  logic               dual_l,
  output logic               accept,
  output logic               last_slot,
  output logic [NCH-1:0]     cap_stb
);
  localparam int DLY_W  = PHASE_W + 1;
  localparam int PACE_W = 2;
  localparam int IDX_W  = $clog2(NCH);

  logic              armed;
  logic [DLY_W-1:0]  dly;
  logic [PACE_W-1:0] pace;
  logic [IDX_W-1:0]  idx;

  assign accept    = armed && (dly == '0) && (pace == '0);
  assign last_slot = (idx == IDX_W'(NCH - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
      dly   <= '0;
      pace  <= '0;
      idx   <= '0;
    end else if (sync_fall) begin
      armed <= 1'b1;
      dly   <= DLY_W'(delay_of(32'(phase_sel), dual_chip));
      pace  <= '0;
      idx   <= '0;
    end else if (armed) begin
      if (dly != '0) begin
        dly <= dly - 1'b1;
      end else if (pace != '0) begin
        pace <= pace - 1'b1;
      end else begin
        pace <= PACE_W'(period_of(dual_l) - 1);
        idx  <= last_slot ? '0 : idx + 1'b1;
      end
    end
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_cap
    assign cap_stb[ch] = accept && (chan_of(32'(idx), dir_l, NCH) == unsigned'(ch));
  end

  AST_CAP_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cap_stb)); // R1
  AST_CAP_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !sync_fall) |=> !accept); // R1
  AST_PHASE_HOLDOFF: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_fall && phase_sel != '0) |=> !accept); // R6
endmodule

// File: rtl/dmx6_xfer_gen.sv
module dmx6_xfer_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_fall,
  input  logic accept,
  input  logic last_slot,
  input  logic split_l,
  output logic xfer_lo,
  output logic xfer_hi
);
  logic lo_q, hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= 1'b0;
      hi_q <= 1'b0;
    end else if (sync_fall) begin
      lo_q <= 1'b0;
      hi_q <= 1'b0;
    end else begin
      lo_q <= accept && last_slot;
      hi_q <= lo_q;
    end
  end

  assign xfer_lo = lo_q;
  assign xfer_hi = split_l ? hi_q : lo_q;

  AST_SPLIT_APART: assert property (@(posedge clk) disable iff (!rst_n)
    (split_l && xfer_lo) |-> !xfer_hi); // R5
  AST_FALL_CANCELS: assert property (@(posedge clk) disable iff (!rst_n)
    sync_fall |=> (!xfer_lo && !xfer_hi)); // R7
endmodule

// File: rtl/dmx6_gap_monitor.sv
module dmx6_gap_monitor #(
  parameter int MIN_GAP = 60
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_fall,
  input  logic pol_edge,
  output logic timing_err
);
  localparam int GAP_W = $clog2(MIN_GAP + 1);
  localparam logic [GAP_W-1:0] GAP_MAX = {GAP_W{1'b1}};

  logic [GAP_W-1:0] gap;
  logic             seen, last_sync, err_q;
  logic             other_kind, too_close;

  assign other_kind = sync_fall ? !last_sync : last_sync;
  assign too_close  = (gap < GAP_W'(MIN_GAP - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap       <= '0;
      seen      <= 1'b0;
      last_sync <= 1'b0;
      err_q     <= 1'b0;
    end else if (sync_fall || pol_edge) begin
      err_q     <= (sync_fall && pol_edge) || (seen && other_kind && too_close);
      gap       <= '0;
      seen      <= 1'b1;
      last_sync <= sync_fall;
    end else begin
      err_q <= 1'b0;
      gap   <= (gap == GAP_MAX) ? gap : gap + 1'b1;
    end
  end

  assign timing_err = err_q;

  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    timing_err |-> $past(sync_fall || pol_edge)); // R9
endmodule

// File: rtl/dmx6_strobe_gen.sv
module dmx6_strobe_gen #(
  parameter int NCH     = 6,
  parameter int PHASE_W = 4,
  parameter int MIN_GAP = 60
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hsync,
  input  logic               pol,
  input  logic               dir_asc,
  input  logic               split_grp,
  input  logic [PHASE_W-1:0] phase_sel,
  input  logic               dual_chip,
  output logic [NCH-1:0]     cap_stb,
  output logic               xfer_lo,
  output logic               xfer_hi,
  output logic               timing_err
);
  logic sync_fall, pol_edge, dir_l, split_l, dual_l;
  logic accept, last_slot;

  dmx6_sync_capture #(.PHASE_W(PHASE_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .hsync(hsync), .pol(pol),
    .dir_asc(dir_asc), .split_grp(split_grp), .dual_chip(dual_chip),
    .sync_fall(sync_fall), .pol_edge(pol_edge),
    .dir_l(dir_l), .split_l(split_l), .dual_l(dual_l)
  );

  dmx6_sequencer #(.NCH(NCH), .PHASE_W(PHASE_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .sync_fall(sync_fall),
    .phase_sel(phase_sel), .dual_chip(dual_chip),
    .dir_l(dir_l), .dual_l(dual_l),
    .accept(accept), .last_slot(last_slot), .cap_stb(cap_stb)
  );

  dmx6_xfer_gen u_xfer (
    .clk(clk), .rst_n(rst_n), .sync_fall(sync_fall),
    .accept(accept), .last_slot(last_slot), .split_l(split_l),
    .xfer_lo(xfer_lo), .xfer_hi(xfer_hi)
  );

  dmx6_gap_monitor #(.MIN_GAP(MIN_GAP)) u_gap (
    .clk(clk), .rst_n(rst_n), .sync_fall(sync_fall), .pol_edge(pol_edge),
    .timing_err(timing_err)
  );

  logic final_cap;
  assign final_cap = dir_l ? cap_stb[NCH-1] : cap_stb[0];

  AST_XFER_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_lo |-> $past(final_cap)); // R4
  AST_DIR_START: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_fall && phase_sel == '0) |=> (dir_l ? cap_stb[0] : cap_stb[NCH-1])); // R7
endmodule

// File: tb/tb_dmx6_strobe_gen.sv
module tb_dmx6_strobe_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hsync = 1'b1, pol = 1'b0;
  logic       dir_asc = 1'b1, split_grp = 1'b0, dual_chip = 1'b0;
  logic [3:0] phase_sel = 4'd0;
  logic [5:0] cap_stb;
  logic       xfer_lo, xfer_hi, timing_err;

  int    checks = 0, errors = 0;
  bit    done = 1'b0;
  string cur_req = "R10";

  // Behavioural reference state
  int cyc, base, dly, per, prev_h, prev_p, last_ev;
  bit bvalid, mdir, msplit, seen, last_sync, exp_err;

  dmx6_strobe_gen dut (
    .clk(clk), .rst_n(rst_n), .hsync(hsync), .pol(pol),
    .dir_asc(dir_asc), .split_grp(split_grp), .phase_sel(phase_sel),
    .dual_chip(dual_chip), .cap_stb(cap_stb), .xfer_lo(xfer_lo),
    .xfer_hi(xfer_hi), .timing_err(timing_err)
  );

  always #2 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) begin
      cyc = 0; prev_h = 0; prev_p = 0; bvalid = 0; seen = 0;
      last_sync = 0; exp_err = 0; last_ev = 0;
    end else begin
      bit f, pe;
      cyc++;
      f  = (prev_h == 1) && (hsync == 1'b0);
      pe = (int'(pol) != prev_p);
      if (f) begin
        base = cyc; bvalid = 1;
        dly = dual_chip ? 2 * int'(phase_sel) : int'(phase_sel);
        per = dual_chip ? 4 : 2;
        mdir = dir_asc; msplit = split_grp;
      end
      if (f || pe) begin
        exp_err = (f && pe) || (seen && (f ? !last_sync : last_sync) && (cyc - last_ev < 60));
        seen = 1; last_ev = cyc; last_sync = f;
      end else exp_err = 0;
      prev_h = int'(hsync); prev_p = int'(pol);
    end
  end

  function automatic bit slot_hit(int t, int p, int want);
    if (t < 0) return 0;
    if (t % p != 0) return 0;
    if (want < 0) return 1;
    return ((t / p) % 6) == want;
  endfunction

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h cycle=%0d", cur_req, what, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      int ecap, elo, ehi, t;
      ecap = 0; elo = 0; ehi = 0;
      if (bvalid) begin
        t = cyc - base - dly;
        if (slot_hit(t, per, -1)) begin
          int k;
          k = (t / per) % 6;
          ecap = 1 << (mdir ? k : 5 - k);
        end
        elo = slot_hit(t - 1, per, 5);
        ehi = msplit ? slot_hit(t - 2, per, 5) : elo;
      end
      chk("cap_stb", int'(cap_stb), ecap);
      chk("xfer_lo", int'(xfer_lo), elo);
      chk("xfer_hi", int'(xfer_hi), ehi);
      chk("timing_err", int'(timing_err), int'(exp_err));
    end
  end

  task automatic cfg(bit d, bit s, int ph, bit du);
    dir_asc = d; split_grp = s; phase_sel = 4'(ph); dual_chip = du;
  endtask

  task automatic line(int low_n, int high_n);
    hsync = 1'b0;
    repeat (low_n) @(negedge clk);
    hsync = 1'b1;
    repeat (high_n) @(negedge clk);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    cur_req = "R10";
    chk("reset cap_stb", int'(cap_stb), 0);
    chk("reset xfer", int'({xfer_lo, xfer_hi}), 0);
    chk("reset timing_err", int'(timing_err), 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);

    cur_req = "R2"; cfg(1, 0, 0, 0); line(40, 3);
    cur_req = "R1"; cfg(1, 0, 1, 1); line(60, 3);
    cur_req = "R3"; cfg(0, 0, 0, 0); line(30, 3);
    cur_req = "R5"; cfg(1, 1, 5, 0); line(40, 3);
    cfg(0, 1, 3, 1); line(70, 3);
    cur_req = "R4"; cfg(0, 0, 2, 1); line(60, 3);
    cur_req = "R6"; cfg(1, 0, 15, 1); line(90, 3);
    cfg(1, 1, 15, 0); line(50, 3);

    cur_req = "R8"; cfg(1, 0, 2, 0);
    hsync = 1'b0;
    repeat (5) @(negedge clk);
    cfg(0, 1, 9, 1);
    repeat (40) @(negedge clk);
    hsync = 1'b1;
    repeat (3) @(negedge clk);

    cur_req = "R7"; cfg(1, 1, 0, 0);
    for (int i = 0; i < 6; i++) line(10, 1);
    cfg(0, 1, 0, 1);
    for (int i = 0; i < 4; i++) line(21, 1);
    cfg(1, 1, 1, 0);
    for (int i = 0; i < 3; i++) line(12, 1);

    cur_req = "R9"; cfg(1, 0, 0, 0);
    hsync = 1'b0;
    repeat (20) @(negedge clk);
    pol = 1'b1;
    repeat (70) @(negedge clk);
    pol = 1'b0;
    repeat (25) @(negedge clk);
    hsync = 1'b1;
    repeat (5) @(negedge clk);
    hsync = 1'b0;
    repeat (100) @(negedge clk);
    pol = 1'b1;
    repeat (10) @(negedge clk);
    hsync = 1'b1;
    repeat (70) @(negedge clk);
    hsync = 1'b0; pol = 1'b0;
    repeat (10) @(negedge clk);
    hsync = 1'b1;
    repeat (4) @(negedge clk);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule